// File: doc/BRIEF.md
# Edge and Level Interrupt Controller

This block gathers event lines from a peripheral into one shared interrupt. Sources are split across two banks of eight bit positions. Each bank has its own sticky status register, enable mask and pair of trigger-mode registers. Bank A uses positions 7, 6, 2, 1 and 0, which carry the transmit slip, output slip, two channel-status buffer transfers and receiver error. Bank B uses positions 3, 2 and 1, which carry two user-data buffer transfers and the arrival of a new subcode block.

A trigger sets a sticky status bit, and that bit stays set until software reads its status register. Any set status bit whose mask bit is 1 drives the shared interrupt. The interrupt pin can be driven in one of three ways: active-high, active-low, or open-drain active-low. In open-drain mode the pin is shown as a data bit plus an output enable.

Software uses a plain register port with an address, write and read strobes, write data and registered read data. There is no data stream at the edge of this block, so no valid/ready handshake is used.

Top module: `evt_irq_ctl`

## Requirements
- R1: After reset, every status, mask and mode register reads 0, the pin mode is 0, `irq_o` is 0 and `irq_oe` is 1.
- R2: Mode {msb,lsb}=00 is rising edge. A 0→1 change on a source sets its status bit at the next clock edge. A source that simply stays high does not set the bit again after a read.
- R3: Mode 01 is falling edge. A 1→0 change sets the status bit, and a 0→1 change does not.
- R4: Modes 10 and 11 are level. The status bit is set on every clock edge at which the source is high, except the edge at which its register is read. A read while the source stays high therefore shows the bit set again on the next read.
- R5: A status bit holds until its register is read. `reg_rdata` returns the value held before the clear, one cycle after `reg_rd`. An edge that arrives in the clearing cycle is kept.
- R6: The interrupt is active when any (status & mask) bit is set in either bank. A masked status bit is still latched and can be read.
- R7: Pin mode 0 drives `irq_o`=active, `irq_oe`=1. Mode 1 drives `irq_o`=!active, `irq_oe`=1. Modes 2 and 3 drive `irq_o`=0 and `irq_oe`=active.
- R8: Only bank A bits 7,6,2,1,0 and bank B bits 3,2,1 exist. All other bits of status, mask and mode read as 0, and their sources are ignored.
- R9: Address map: 0 status A, 1 status B, 2 mask A, 3 mask B, 4 mode-msb A, 5 mode-lsb A, 6 mode-msb B, 7 mode-lsb B, 8 pin mode in bits [1:0]. Writes to status are ignored. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_a | input | 8 | Bank A event sources |
| src_b | input | 8 | Bank B event sources |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears status on a status address) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_rd` |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
A source change applied between clock edges shows up in status at the next rising edge. The interrupt pin follows on that same edge, because it is decoded combinationally from registers. A read strobe returns data and clears status at the one edge where it is sampled. The bench therefore drives inputs on falling edges and samples one falling edge later. Each read is followed by an idle cycle, so the re-set of a level bit falls into a known edge before the next read.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  typedef enum logic [3:0] {
    SEL_ST_A  = 4'd0,
    SEL_ST_B  = 4'd1,
    SEL_MSK_A = 4'd2,
    SEL_MSK_B = 4'd3,
    SEL_MSB_A = 4'd4,
    SEL_LSB_A = 4'd5,
    SEL_MSB_B = 4'd6,
    SEL_LSB_B = 4'd7,
    SEL_PIN   = 4'd8
  } reg_sel_e;

  typedef enum logic [1:0] {
    PIN_HIGH = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_OD   = 2'd2,
    PIN_OD_X = 2'd3
  } pin_mode_e;
endpackage

// File: rtl/evt_irq_bank.sv
module evt_irq_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         clr,
  input  logic         wr_mask,
  input  logic         wr_msb,
  input  logic         wr_lsb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic [W-1:0] mode_msb,
  output logic [W-1:0] mode_lsb,
  output logic         hit
);
  logic [W-1:0] src_q, rise, fall, edge_hit, lvl_hit, clr_v, st_n;

  assign rise     = src & ~src_q;
  assign fall     = ~src & src_q;
  assign edge_hit = (~mode_msb & ~mode_lsb & rise) | (~mode_msb & mode_lsb & fall);
  assign lvl_hit  = mode_msb & src;
  assign clr_v    = {W{clr}};
  assign st_n     = ((status & ~clr_v) | edge_hit | (lvl_hit & ~clr_v)) & IMPL;
  assign hit      = |(status & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      status   <= '0;
      mask     <= '0;
      mode_msb <= '0;
      mode_lsb <= '0;
    end else begin
      src_q  <= src;
      status <= st_n;
      if (wr_mask) mask     <= wdata & IMPL;
      if (wr_msb)  mode_msb <= wdata & IMPL;
      if (wr_lsb)  mode_lsb <= wdata & IMPL;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_chk
      // R2
      rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_msb[i] && !mode_lsb[i] && $rose(src[i])) |=> status[i]);
      // R4
      level_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_msb[i] && src[i] && !clr) |=> status[i]);
      // R5
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[i] && !clr) |=> status[i]);
    end else begin : g_none
      // R8
      absent_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status[i] && !mask[i]);
    end
  end
endmodule

// File: rtl/evt_irq_pin.sv
module evt_irq_pin
  import evt_irq_pkg::*;
(
  input  pin_mode_e mode,
  input  logic      active,
  output logic      irq_o,
  output logic      irq_oe
);
  always_comb begin
    case (mode)
      PIN_HIGH: begin irq_o = active;  irq_oe = 1'b1;   end
      PIN_LOW:  begin irq_o = !active; irq_oe = 1'b1;   end
      default:  begin irq_o = 1'b0;    irq_oe = active; end
    endcase
  end
endmodule

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl
  import evt_irq_pkg::*;
#(
  parameter int W = 8,
  parameter int ADDR_W = 4,
  parameter logic [W-1:0] IMPL_A = 8'hC7,
  parameter logic [W-1:0] IMPL_B = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      src_a,
  input  logic [W-1:0]      src_b,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              irq_o,
  output logic              irq_oe
);
  localparam int PIN_W = 2;

  logic [W-1:0] st_a, mk_a, ms_a, ls_a, st_b, mk_b, ms_b, ls_b, rd_mux;
  logic         hit_a, hit_b;
  pin_mode_e    pin_mode;

  function automatic logic sel(input logic [ADDR_W-1:0] a, input reg_sel_e s);
    return a == ADDR_W'(s);
  endfunction

  evt_irq_bank #(.W(W), .IMPL(IMPL_A)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .src(src_a),
    .clr(reg_rd && sel(reg_addr, SEL_ST_A)),
    .wr_mask(reg_wr && sel(reg_addr, SEL_MSK_A)),
    .wr_msb(reg_wr && sel(reg_addr, SEL_MSB_A)),
    .wr_lsb(reg_wr && sel(reg_addr, SEL_LSB_A)),
    .wdata(reg_wdata), .status(st_a), .mask(mk_a),
    .mode_msb(ms_a), .mode_lsb(ls_a), .hit(hit_a)
  );

  evt_irq_bank #(.W(W), .IMPL(IMPL_B)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .src(src_b),
    .clr(reg_rd && sel(reg_addr, SEL_ST_B)),
    .wr_mask(reg_wr && sel(reg_addr, SEL_MSK_B)),
    .wr_msb(reg_wr && sel(reg_addr, SEL_MSB_B)),
    .wr_lsb(reg_wr && sel(reg_addr, SEL_LSB_B)),
    .wdata(reg_wdata), .status(st_b), .mask(mk_b),
    .mode_msb(ms_b), .mode_lsb(ls_b), .hit(hit_b)
  );

  evt_irq_pin u_pin (
    .mode(pin_mode), .active(hit_a || hit_b), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(SEL_ST_A):  rd_mux = st_a;
      ADDR_W'(SEL_ST_B):  rd_mux = st_b;
      ADDR_W'(SEL_MSK_A): rd_mux = mk_a;
      ADDR_W'(SEL_MSK_B): rd_mux = mk_b;
      ADDR_W'(SEL_MSB_A): rd_mux = ms_a;
      ADDR_W'(SEL_LSB_A): rd_mux = ls_a;
      ADDR_W'(SEL_MSB_B): rd_mux = ms_b;
      ADDR_W'(SEL_LSB_B): rd_mux = ls_b;
      ADDR_W'(SEL_PIN):   rd_mux = W'(pin_mode);
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      pin_mode  <= PIN_HIGH;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      if (reg_wr && sel(reg_addr, SEL_PIN)) pin_mode <= pin_mode_e'(reg_wdata[PIN_W-1:0]);
    end
  end

  // R5
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel(reg_addr, SEL_ST_A)) |=> reg_rdata == $past(st_a));
  // R7
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mode[1] |-> !(irq_oe && irq_o));
  // R6
  quiet_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode == PIN_HIGH && (st_a & mk_a) == '0 && (st_b & mk_b) == '0) |-> !irq_o);
endmodule

// File: tb/evt_irq_ctl_bench.sv
module evt_irq_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_a = '0, src_b = '0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_o, irq_oe;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_ctl u_evt_irq_ctl (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
    tick();
  endtask

  task automatic t_reset();
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), rv);
      check("R1 reg", rv, 8'h00);
    end
    check("R1 irq_o", {7'b0, irq_o}, 8'h00);
    check("R1 irq_oe", {7'b0, irq_oe}, 8'h01);
  endtask

  task automatic t_rise();
    src_a[0] = 1'b1; tick();
    check("R6 masked no irq", {7'b0, irq_o}, 8'h00);
    rd(0, rv); check("R2 rise sets", rv, 8'h01);
    rd(0, rv); check("R2 held high no reset", rv, 8'h00);
    src_a[0] = 1'b0; tick();
    rd(0, rv); check("R2 fall ignored", rv, 8'h00);
  endtask

  task automatic t_fall();
    wr(5, 8'h02);
    src_a[1] = 1'b1; tick(); tick();
    rd(0, rv); check("R3 rise ignored", rv, 8'h00);
    src_a[1] = 1'b0; tick();
    rd(0, rv); check("R3 fall sets", rv, 8'h02);
    wr(5, 8'h00);
  endtask

  task automatic t_level();
    wr(6, 8'h0C); wr(7, 8'h04);
    src_b[3] = 1'b1; src_b[2] = 1'b1; tick();
    rd(1, rv); check("R4 level 10/11", rv, 8'h0C);
    rd(1, rv); check("R4 level re-sets", rv, 8'h0C);
    src_b[3] = 1'b0; src_b[2] = 1'b0; tick();
    rd(1, rv); check("R4 last level kept", rv, 8'h0C);
    rd(1, rv); check("R4 cleared", rv, 8'h00);
    wr(6, 8'h00); wr(7, 8'h00);
  endtask

  task automatic t_sticky();
    reg_addr = 0; reg_rd = 1'b1; src_a[7] = 1'b1;
    tick();
    reg_rd = 1'b0; src_a[7] = 1'b0;
    check("R5 read before edge", reg_rdata, 8'h00);
    tick(); tick();
    rd(0, rv); check("R5 edge in clear cycle kept", rv, 8'h80);
  endtask

  task automatic t_pin();
    wr(2, 8'h01);
    src_a[0] = 1'b1; tick(); src_a[0] = 1'b0;
    check("R6 irq from A", {6'b0, irq_o, irq_oe}, 8'h03);
    wr(8, 8'h01);
    check("R7 low active", {6'b0, irq_o, irq_oe}, 8'h01);
    wr(8, 8'h02);
    check("R7 od active", {6'b0, irq_o, irq_oe}, 8'h01);
    rd(0, rv);
    check("R7 od released", {6'b0, irq_o, irq_oe}, 8'h00);
    wr(8, 8'h03);
    check("R7 mode 3 released", {6'b0, irq_o, irq_oe}, 8'h00);
    wr(8, 8'h01);
    check("R7 low idle", {6'b0, irq_o, irq_oe}, 8'h03);
    wr(8, 8'h00);
    check("R7 high idle", {6'b0, irq_o, irq_oe}, 8'h01);
    wr(3, 8'h02);
    src_b[1] = 1'b1; tick(); src_b[1] = 1'b0;
    check("R6 irq from B", {7'b0, irq_o}, 8'h01);
    rd(1, rv); check("R6 B status", rv, 8'h02);
    check("R6 irq drops", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_impl();
    wr(2, 8'hFF); rd(2, rv); check("R8 mask A bits", rv, 8'hC7);
    wr(6, 8'hFF); rd(6, rv); check("R8 msb B bits", rv, 8'h0E);
    wr(6, 8'h00);
    src_a[3] = 1'b1; src_b[0] = 1'b1; tick();
    src_a[3] = 1'b0; src_b[0] = 1'b0;
    check("R8 no irq", {7'b0, irq_o}, 8'h00);
    rd(0, rv); check("R8 A bit3 ignored", rv, 8'h00);
    rd(1, rv); check("R8 B bit0 ignored", rv, 8'h00);
  endtask

  task automatic t_map();
    wr(0, 8'hFF); rd(0, rv); check("R9 status write ignored", rv, 8'h00);
    wr(8, 8'h02); rd(8, rv); check("R9 pin reg", rv, 8'h02);
    wr(8, 8'h00);
    rd(12, rv); check("R9 unmapped", rv, 8'h00);
    wr(4, 8'h40); rd(4, rv); check("R9 msb A", rv, 8'h40);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_level();
    t_sticky();
    t_pin();
    t_impl();
    t_map();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule